// File: doc/BRIEF.md
# Single-Register I2C Target

This block is an I2C target that holds one 8-bit control byte and reports one 8-bit status byte. It has no internal address pointer. A write transaction to its 7-bit device address loads the control byte. A read transaction returns the status byte supplied by the surrounding logic. When a read completes, the block emits a one-cycle strobe, so the owner of the status bits can clear any sticky flags that were just reported.

The block runs on a fast system clock. SCL and SDA must already be synchronised into that clock domain before they reach the block. Pulling SDA low is requested through an output-enable: when it is 1, the pad drives low; when it is 0, the pad releases. START and STOP conditions are recognised at any point and return the protocol logic to a known state. Clock stretching, bursts of more than one byte, 10-bit addressing and general call are not handled.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `stat_rd_o` is 0 and `ctrl_o` equals `CTRL_RST` (default 8'h00).
- R2: The address byte carries the 7-bit address followed by a direction bit. A value of 0 in bit 0 means write. When a write is addressed to `DEV_ADDR`, the target pulls SDA low during the ninth clock. It then takes 8 data bits, most significant first, and pulls SDA low again in the following ninth clock.
- R3: `ctrl_o` keeps its old value until all 8 data bits of a write have been received. It takes the new byte when the data acknowledge clock begins.
- R4: When the address does not match, the target never pulls SDA low and leaves `ctrl_o` unchanged until the next START.
- R5: When a read is addressed to `DEV_ADDR` (bit 0 of the address byte is 1), the target acknowledges. It then drives the status byte most significant bit first, and releases SDA in the master's acknowledge clock.
- R6: The status byte is captured at the SCL falling edge that ends the address acknowledge. Later changes to `status_i` do not alter the byte being sent.
- R7: `stat_rd_o` pulses high for exactly one cycle, on the SCL rising edge of the master's acknowledge bit after a read byte. It does not pulse during the address or the data bits.
- R8: A STOP at any point returns the target to idle with SDA released. A write cut short by STOP leaves `ctrl_o` unchanged, and the next transaction works normally.
- R9: A repeated START in the middle of a transaction restarts the address phase.
- R10: `sda_oe_o` changes only while SCL is low. It only becomes 1 after an SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| status_i | input | 8 | Status byte returned on reads |
| ctrl_o | output | 8 | Control byte loaded by writes |
| stat_rd_o | output | 1 | One-cycle pulse when a status read completes |

## Verification
A wrong bit count or a wrong state shows up at the ports within one SCL period. The acknowledge low appears in the wrong clock, a data bit lands shifted, or `ctrl_o` changes before the ninth clock. A corrupt status capture shows up as a wrong bit on SDA during the read byte. A misplaced clear strobe shows up as a strobe count that moves before the acknowledge clock instead of at it. A missed STOP or START detection leaves the target out of step, and the transaction that follows exposes it.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } slv_st_e;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edges while SCL is steadily high are bus conditions
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
  import i2c_slv_pkg::*;
#(
  parameter int unsigned ADW = 7,
  parameter int unsigned DW  = 8,
  parameter logic [ADW-1:0] DEV_ADDR = 7'h24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-1:0] status_i,
  output logic          sda_oe_o,
  output logic          ctrl_we_o,
  output logic [DW-1:0] ctrl_wdata_o,
  output logic          stat_rd_o
);
  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] ABITS = CW'(ADW + 1);
  localparam logic [CW-1:0] DBITS = CW'(DW);
  localparam logic [CW-1:0] DLAST = CW'(DW - 1);

  slv_st_e       st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          oe_q, oe_n;
  logic          rw_q, rw_n;
  logic          rd_q, rd_n;
  logic          we_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    oe_n  = oe_q;
    rw_n  = rw_q;
    rd_n  = 1'b0;
    we_n  = 1'b0;
    if (stop_i) begin
      st_n  = ST_IDLE;
      oe_n  = 1'b0;
      cnt_n = '0;
    end else if (start_i) begin
      st_n  = ST_ADDR;
      oe_n  = 1'b0;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh_n  = {sh_q[DW-2:0], sda_i};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == ABITS) begin
            cnt_n = '0;
            if (sh_q[ADW:1] == DEV_ADDR) begin
              oe_n = 1'b1;
              rw_n = sh_q[0];
              st_n = ST_AACK;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall_i) begin
            cnt_n = '0;
            if (rw_q) begin
              sh_n = status_i;
              oe_n = ~status_i[DW-1];
              st_n = ST_RDAT;
            end else begin
              oe_n = 1'b0;
              st_n = ST_WDAT;
            end
          end
        end
        ST_WDAT: begin
          if (scl_rise_i) begin
            sh_n  = {sh_q[DW-2:0], sda_i};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == DBITS) begin
            cnt_n = '0;
            oe_n  = 1'b1;
            we_n  = 1'b1;
            st_n  = ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall_i) begin
            oe_n = 1'b0;
            st_n = ST_IDLE;
          end
        end
        ST_RDAT: begin
          if (scl_fall_i) begin
            if (cnt_q == DLAST) begin
              cnt_n = '0;
              oe_n  = 1'b0;
              st_n  = ST_RACK;
            end else begin
              cnt_n = cnt_q + 1'b1;
              sh_n  = {sh_q[DW-2:0], 1'b0};
              oe_n  = ~sh_q[DW-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            rd_n = 1'b1;
            st_n = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      oe_q  <= 1'b0;
      rw_q  <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      oe_q  <= oe_n;
      rw_q  <= rw_n;
      rd_q  <= rd_n;
    end
  end

  assign sda_oe_o     = oe_q;
  assign stat_rd_o    = rd_q;
  assign ctrl_we_o    = we_n;
  assign ctrl_wdata_o = sh_q;

  // R7: the clear strobe lasts one cycle
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_o |=> !stat_rd_o);
  // R10: the target only starts pulling low after an SCL fall
  a_r10_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(scl_fall_i));
  // R8: STOP leaves the target idle with SDA released
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (st_q == ST_IDLE) && !oe_q);
  // R9: START enters the address phase
  a_r9_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> (st_q == ST_ADDR) && (cnt_q == '0));
  // R4: no drive while the address is shifting in
  a_r4_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR) |-> !oe_q);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int unsigned ADW = 7,
  parameter int unsigned DW  = 8,
  parameter logic [ADW-1:0] DEV_ADDR = 7'h24,
  parameter logic [DW-1:0]  CTRL_RST = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] ctrl_o,
  output logic          stat_rd_o
);
  logic scl_rise, scl_fall, start_det, stop_det;
  logic ctrl_we;
  logic [DW-1:0] ctrl_wdata, ctrl_q;

  i2c_bus_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_slv_fsm #(
    .ADW      (ADW),
    .DW       (DW),
    .DEV_ADDR (DEV_ADDR)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_i        (sda_i),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_i      (start_det),
    .stop_i       (stop_det),
    .status_i     (status_i),
    .sda_oe_o     (sda_oe_o),
    .ctrl_we_o    (ctrl_we),
    .ctrl_wdata_o (ctrl_wdata),
    .stat_rd_o    (stat_rd_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_wdata;
    end
  end

  assign ctrl_o = ctrl_q;

  // R3: the control byte only moves as the data acknowledge begins
  a_r3_ctrl_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> sda_oe_o && !scl_i);
endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  localparam int H = 6;
  localparam logic [6:0] ADDR = 7'h24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [7:0] status = 8'h00;
  logic sda_oe, stat_rd;
  logic [7:0] ctrl;
  logic sda_line;
  int n_run = 0;
  int n_fail = 0;
  int strobes = 0;
  int oe_hi_changes = 0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_slave u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe),
    .status_i  (status),
    .ctrl_o    (ctrl),
    .stat_rd_o (stat_rd)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (stat_rd) strobes++;
      if (prev_scl && scl && (prev_oe != sda_oe)) oe_hi_changes++;
    end
    prev_scl <= scl;
    prev_oe  <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic b_start();
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H);
    sda_m = 1'b0; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic b_stop();
    sda_m = 1'b0; wt(H); scl = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wt(H); scl = 1'b1; wt(2*H); scl = 1'b0; wt(H);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H);
    b = sda_line; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(stat_rd == 1'b0, "R1 stat_rd", stat_rd, 0);
    chk(ctrl == 8'h00, "R1 ctrl", ctrl, 8'h00);
  endtask

  task automatic t_write(input logic [7:0] v);
    logic ack;
    logic [7:0] old;
    old = ctrl;
    b_start();
    put_byte({ADDR, 1'b0}, ack);
    chk(ack == 1'b0, "R2 addr ack", ack, 0);
    for (int i = 7; i >= 1; i--) put_bit(v[i]);
    chk(ctrl == old, "R3 ctrl before last bit", ctrl, old);
    put_bit(v[0]);
    chk(ctrl == v, "R3 ctrl at ack clock", ctrl, v);
    get_bit(ack);
    chk(ack == 1'b0, "R2 data ack", ack, 0);
    b_stop();
    chk(ctrl == v, "R2 ctrl value", ctrl, v);
    chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    logic [7:0] old;
    old = ctrl;
    b_start();
    put_byte({ADDR ^ 7'h01, 1'b0}, ack);
    chk(ack == 1'b1, "R4 no addr ack", ack, 1);
    put_byte(8'hC3, ack);
    chk(ack == 1'b1, "R4 no data ack", ack, 1);
    b_stop();
    chk(ctrl == old, "R4 ctrl unchanged", ctrl, old);
  endtask

  task automatic t_read(input logic [7:0] s, input logic [7:0] s_late);
    logic ack, nak;
    logic [7:0] got;
    int s0;
    status = s;
    b_start();
    s0 = strobes;
    put_byte({ADDR, 1'b1}, ack);
    chk(ack == 1'b0, "R5 read addr ack", ack, 0);
    status = s_late;
    get_byte(got);
    chk(got == s, "R6 status byte held", got, s);
    chk(strobes == s0, "R7 no strobe before ack bit", strobes, s0);
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H);
    nak = sda_line;
    chk(nak == 1'b1, "R5 SDA released at master ack", nak, 1);
    wt(H); scl = 1'b0; wt(H);
    chk(strobes == s0 + 1, "R7 one strobe at ack bit", strobes, s0 + 1);
    b_stop();
  endtask

  task automatic t_stop_abort();
    logic ack;
    logic [7:0] old;
    old = ctrl;
    b_start();
    put_byte({ADDR, 1'b0}, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    b_stop();
    chk(ctrl == old, "R8 aborted write", ctrl, old);
    t_write(8'h5A);
  endtask

  task automatic t_restart();
    logic ack, nak;
    logic [7:0] got, old;
    old = ctrl;
    status = 8'h96;
    b_start();
    put_byte({ADDR, 1'b0}, ack);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    b_start();
    put_byte({ADDR, 1'b1}, ack);
    chk(ack == 1'b0, "R9 ack after repeated start", ack, 0);
    get_byte(got);
    chk(got == 8'h96, "R9 read after repeated start", got, 8'h96);
    get_bit(nak);
    b_stop();
    chk(ctrl == old, "R9 ctrl unchanged", ctrl, old);
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(3);
    t_reset();
    t_write(8'hA7);
    t_write(8'h01);
    t_mismatch();
    t_read(8'hA5, 8'h3C);
    t_read(8'h80, 8'h7F);
    t_stop_abort();
    t_restart();
    chk(oe_hi_changes == 0, "R10 sda_oe moved with SCL high", oe_hi_changes, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule